// File: doc/BRIEF.md
# Retire-Stage Interrupt Sequencer

This block sits beside the retire logic of an out-of-order core and decides when an external interrupt request is actually taken. It watches a level request from the interrupt controller. When no squash or drain is under way, it captures the request into a holding state. In that state it tells the front end to stop fetching, and it tells retire that nothing may commit in the current cycle.

While holding, the block checks the request again every cycle. If the controller has withdrawn the request, the block backs out. It pulses a clear toward the front end so that fetch continues on the original path. If the request is still present, the block waits until taking interrupts is allowed and no instruction remains in flight. It then pulses an acknowledge to the controller, pulses the same clear toward the front end, and enters a trap phase. After a fixed, parameterised number of cycles it emits a one-cycle squash/redirect pulse tagged with thread index zero, and one cycle later it is idle again.

Top module: `intr_retire_seq`

## Requirements
- R1: While rst_n is low at a clock edge, every output is 0 after that edge and the block returns to idle.
- R2: In idle, a high irq_pending with trap_squash, ctx_squash and drain_soon all low at an edge makes fetch_hold high from the next cycle.
- R3: No new request is captured while any of trap_squash, ctx_squash or drain_soon is high, nor while the trap phase or the squash cycle is in progress; fetch_hold stays 0 in those cases.
- R4: retire_block is high exactly in the cycles where fetch_hold is high.
- R5: If irq_pending is low at an edge while holding, then clear_intr is high for the next cycle only, fetch_hold drops, and irq_ack stays 0.
- R6: While holding with irq_pending high, if can_handle or inflight_empty is low at an edge, the block keeps holding and gives no acknowledge.
- R7: While holding, irq_pending, can_handle and inflight_empty all high at an edge cause irq_ack and clear_intr to be high for the next cycle only. In that same cycle fetch_hold drops and trap_inflight rises.
- R8: trap_inflight stays high for exactly TRAP_LAT cycles (parameter, at least 1), starting with the acknowledge cycle. squash_pulse is high for the single cycle right after, and squash_tid equals THREAD_ID (0) during it.
- R9: The cycle after squash_pulse the block is idle with all outputs 0, and a request present then may be captured at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pending | input | 1 | Level request from the interrupt controller |
| trap_squash | input | 1 | A trap squash is active |
| ctx_squash | input | 1 | A squash from external context access is active |
| drain_soon | input | 1 | Pipeline drain is imminent |
| can_handle | input | 1 | Taking interrupts is currently permitted |
| inflight_empty | input | 1 | No instruction is in flight |
| fetch_hold | output | 1 | Interrupt pending toward fetch/issue: stop fetching |
| retire_block | output | 1 | No instruction may retire this cycle |
| clear_intr | output | 1 | One-cycle pulse: front end may drop its pending state |
| irq_ack | output | 1 | One-cycle acknowledge to the interrupt controller |
| trap_inflight | output | 1 | Trap taken, squash not yet issued |
| squash_pulse | output | 1 | One-cycle trap squash/redirect event |
| squash_tid | output | TID_W | Thread index of the squash |

## Verification
Each result falls at a fixed distance from the edge that samples its cause. Capture, cancel and take are visible one cycle after the deciding edge. The squash comes TRAP_LAT cycles after the acknowledge cycle, and idle returns one cycle after the squash. The scoreboard driver therefore pushes one expected output vector for every cycle it drives. The monitor pops and compares that vector shortly after the next rising edge, so every output is checked in every cycle, not only where a change is expected.

// File: rtl/intr_seq_pkg.sv
// Shared types for the retire-stage interrupt sequencer.
// Assumes: one interrupt context, one sequencer per core.
package intr_seq_pkg;

    // Sequencer phases: idle, holding a captured request, trap delay, squash cycle
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_TRAP = 2'd2,
        SEQ_FIRE = 2'd3
    } seq_state_t;

endpackage

// File: rtl/intr_admit_gate.sv
// Decides whether a pending request may be captured this cycle.
// Assumes: the caller applies it only in the idle phase, which covers the
// "already captured" and "trap pending" exclusions.
module intr_admit_gate (
    input  logic irq_pending,
    input  logic trap_squash,
    input  logic ctx_squash,
    input  logic drain_soon,
    output logic admit
);

    // Capture only when no squash or drain is in progress
    always_comb begin
        admit = irq_pending && !trap_squash && !ctx_squash && !drain_soon;
    end

endmodule

// File: rtl/trap_delay_ctr.sv
// Down-counter that times the gap between taking a trap and the squash.
// Assumes: load is a single-cycle strobe; done is read only in the trap phase.
module trap_delay_ctr #(
    parameter int TRAP_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CW = (TRAP_LAT > 1) ? $clog2(TRAP_LAT) : 1;
    localparam logic [CW-1:0] START = CW'(TRAP_LAT - 1);

    logic [CW-1:0] cnt;

    // Load on trap entry, then count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Zero means the delay has elapsed
    always_comb begin
        done = (cnt == '0);
    end

endmodule

// File: rtl/intr_seq_fsm.sv
// Phase controller: capture, cancel or take, trap delay, squash.
// Assumes: admit already excludes squash and drain; delay_done comes from a
// counter loaded by ctr_load on the take edge.
module intr_seq_fsm
    import intr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       admit,
    input  logic       irq_pending,
    input  logic       can_handle,
    input  logic       inflight_empty,
    input  logic       delay_done,
    output seq_state_t state,
    output logic       ctr_load,
    output logic       clear_intr,
    output logic       irq_ack
);

    seq_state_t state_nx;
    logic       clr_nx;
    logic       ack_nx;

    // Next phase and the strobes that go with each transition
    always_comb begin
        state_nx = state;
        clr_nx   = 1'b0;
        ack_nx   = 1'b0;
        ctr_load = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (admit) state_nx = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (!irq_pending) begin
                    state_nx = SEQ_IDLE;
                    clr_nx   = 1'b1;
                end else if (can_handle && inflight_empty) begin
                    state_nx = SEQ_TRAP;
                    clr_nx   = 1'b1;
                    ack_nx   = 1'b1;
                    ctr_load = 1'b1;
                end
            end
            SEQ_TRAP: begin
                if (delay_done) state_nx = SEQ_FIRE;
            end
            SEQ_FIRE: begin
                state_nx = SEQ_IDLE;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    // Phase register and registered one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            clear_intr <= 1'b0;
            irq_ack    <= 1'b0;
        end else begin
            state      <= state_nx;
            clear_intr <= clr_nx;
            irq_ack    <= ack_nx;
        end
    end

endmodule

// File: rtl/intr_retire_seq.sv
// Top of the retire-stage interrupt sequencer.
// Holds fetch and retire while an interrupt is captured. Takes the interrupt
// once the pipeline is empty and permitted, then issues a delayed squash.
// Assumes: all inputs are synchronous to clk; a single thread.
module intr_retire_seq
    import intr_seq_pkg::*;
#(
    parameter int TRAP_LAT  = 3,
    parameter int TID_W     = 1,
    parameter int THREAD_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pending,
    input  logic             trap_squash,
    input  logic             ctx_squash,
    input  logic             drain_soon,
    input  logic             can_handle,
    input  logic             inflight_empty,
    output logic             fetch_hold,
    output logic             retire_block,
    output logic             clear_intr,
    output logic             irq_ack,
    output logic             trap_inflight,
    output logic             squash_pulse,
    output logic [TID_W-1:0] squash_tid
);

    localparam logic [TID_W-1:0] TID_VAL = TID_W'(THREAD_ID);

    logic       admit;
    logic       ctr_load;
    logic       delay_done;
    seq_state_t state;

    intr_admit_gate i_gate (
        .irq_pending (irq_pending),
        .trap_squash (trap_squash),
        .ctx_squash  (ctx_squash),
        .drain_soon  (drain_soon),
        .admit       (admit)
    );

    trap_delay_ctr #(
        .TRAP_LAT (TRAP_LAT)
    ) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctr_load),
        .done  (delay_done)
    );

    intr_seq_fsm i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .admit          (admit),
        .irq_pending    (irq_pending),
        .can_handle     (can_handle),
        .inflight_empty (inflight_empty),
        .delay_done     (delay_done),
        .state          (state),
        .ctr_load       (ctr_load),
        .clear_intr     (clear_intr),
        .irq_ack        (irq_ack)
    );

    // Decode the phase into the level outputs
    always_comb begin
        fetch_hold    = (state == SEQ_WAIT);
        retire_block  = (state == SEQ_WAIT);
        trap_inflight = (state == SEQ_TRAP);
        squash_pulse  = (state == SEQ_FIRE);
        squash_tid    = (state == SEQ_FIRE) ? TID_VAL : '0;
    end

endmodule

// File: rtl/intr_seq_checker.sv
// Port-level properties of the interrupt sequencer, bound to every instance.
// Assumes: rst_n low for at least one edge at start of run.
module intr_seq_checker #(
    parameter int TRAP_LAT = 3,
    parameter int TID_W    = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pending,
    input logic             trap_squash,
    input logic             ctx_squash,
    input logic             drain_soon,
    input logic             can_handle,
    input logic             inflight_empty,
    input logic             fetch_hold,
    input logic             retire_block,
    input logic             clear_intr,
    input logic             irq_ack,
    input logic             trap_inflight,
    input logic             squash_pulse,
    input logic [TID_W-1:0] squash_tid
);

    int unsigned infl_run;

    // Length of the current run of trap_inflight cycles
    always_ff @(posedge clk) begin
        if (!rst_n)             infl_run <= 0;
        else if (trap_inflight) infl_run <= infl_run + 1;
        else                    infl_run <= 0;
    end

    AST_ADMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_hold) |-> $past(irq_pending && !trap_squash && !ctx_squash && !drain_soon)); // R2

    AST_NO_CAPTURE_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_inflight |=> !fetch_hold); // R3

    AST_HOLD_BLOCKS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_hold) |-> retire_block); // R4

    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && !irq_pending) |=> (clear_intr && !irq_ack && !fetch_hold)); // R5

    AST_KEEP_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && irq_pending && !(can_handle && inflight_empty)) |=> (fetch_hold && !irq_ack)); // R6

    AST_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && irq_pending && can_handle && inflight_empty) |=> (irq_ack && clear_intr && trap_inflight)); // R7

    AST_TRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        squash_pulse |-> (infl_run == TRAP_LAT)); // R8

    AST_SQUASH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        squash_pulse |=> (!squash_pulse && !trap_inflight && !fetch_hold)); // R9

endmodule

bind intr_retire_seq intr_seq_checker #(
    .TRAP_LAT (TRAP_LAT),
    .TID_W    (TID_W)
) i_chk (.*);

// File: tb/test_intr_retire_seq.sv
// Scoreboard bench: the driver pushes one expected output vector per driven
// cycle; the monitor pops and compares it 2 ns after the following edge.
module test_intr_retire_seq;

    localparam int LAT = 3;

    // Expected vector: {fetch_hold, retire_block, clear_intr, irq_ack,
    //                   trap_inflight, squash_pulse, squash_tid}
    localparam logic [6:0] NONE = 7'b0000000;
    localparam logic [6:0] HOLD = 7'b1100000;
    localparam logic [6:0] CLR  = 7'b0010000;
    localparam logic [6:0] TAKE = 7'b0011100;
    localparam logic [6:0] TI   = 7'b0000100;
    localparam logic [6:0] SQ   = 7'b0000010;

    typedef struct {
        logic [6:0] v;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_pending = 1'b0, trap_squash = 1'b0, ctx_squash = 1'b0;
    logic drain_soon = 1'b0, can_handle = 1'b0, inflight_empty = 1'b0;
    logic fetch_hold, retire_block, clear_intr, irq_ack;
    logic trap_inflight, squash_pulse;
    logic [0:0] squash_tid;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intr_retire_seq #(.TRAP_LAT(LAT), .TID_W(1), .THREAD_ID(0)) i_intr_retire_seq (
        .clk, .rst_n, .irq_pending, .trap_squash, .ctx_squash, .drain_soon,
        .can_handle, .inflight_empty, .fetch_hold, .retire_block, .clear_intr,
        .irq_ack, .trap_inflight, .squash_pulse, .squash_tid
    );

    // Drive one cycle of inputs and queue the outputs due after the next edge
    task automatic cyc(input logic r, input logic ip, input logic ts, input logic cs,
                       input logic dr, input logic ch, input logic ie,
                       input logic [6:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = r; irq_pending = ip; trap_squash = ts; ctx_squash = cs;
        drain_soon = dr; can_handle = ch; inflight_empty = ie;
        it.v = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: pop and compare one expected vector per edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it = q.pop_front();
            act = {fetch_hold, retire_block, clear_intr, irq_ack,
                   trap_inflight, squash_pulse, squash_tid};
            n_chk++;
            if (act !== it.v) begin
                n_bad++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.v);
            end
        end
    end

    // Directed stimulus
    initial begin
        // R1 reset state
        cyc(0, 1, 0, 0, 0, 1, 1, NONE, "R1 reset");
        cyc(0, 1, 0, 0, 0, 1, 1, NONE, "R1 reset");
        cyc(1, 0, 0, 0, 0, 0, 0, NONE, "R1 idle");

        // R2 capture, R6 wait, R7 take, R8 delay, R9 return
        cyc(1, 1, 0, 0, 0, 1, 0, HOLD, "R2 capture");
        cyc(1, 1, 0, 0, 0, 1, 0, HOLD, "R6 inflight busy");
        cyc(1, 1, 0, 0, 0, 0, 1, HOLD, "R6 not permitted");
        cyc(1, 1, 0, 0, 0, 1, 1, TAKE, "R7 take");
        cyc(1, 1, 0, 0, 0, 1, 1, TI,   "R8 trap delay");
        cyc(1, 1, 0, 0, 0, 1, 1, TI,   "R8 trap delay");
        cyc(1, 1, 0, 0, 0, 1, 1, SQ,   "R8 squash");
        cyc(1, 1, 0, 0, 0, 1, 0, NONE, "R9 idle after squash");
        cyc(1, 1, 0, 0, 0, 1, 0, HOLD, "R9 recapture");

        // R5 cancel
        cyc(1, 0, 0, 0, 0, 1, 1, CLR,  "R5 cancel");
        cyc(1, 0, 0, 0, 0, 1, 1, NONE, "R5 after cancel");

        // R3 blockers
        cyc(1, 1, 1, 0, 0, 1, 1, NONE, "R3 trap squash");
        cyc(1, 1, 0, 1, 0, 1, 1, NONE, "R3 ctx squash");
        cyc(1, 1, 0, 0, 1, 1, 1, NONE, "R3 drain");
        cyc(1, 1, 0, 0, 0, 0, 0, HOLD, "R4 hold and retire block");
        cyc(1, 1, 1, 1, 1, 0, 0, HOLD, "R6 blockers do not cancel");
        cyc(1, 0, 0, 0, 0, 0, 0, CLR,  "R5 cancel");
        cyc(1, 0, 0, 0, 0, 0, 0, NONE, "R5 after cancel");

        // R1 reset in the middle of a trap
        cyc(1, 1, 0, 0, 0, 1, 1, HOLD, "R2 capture");
        cyc(1, 1, 0, 0, 0, 1, 1, TAKE, "R7 immediate take");
        cyc(0, 1, 0, 0, 0, 1, 1, NONE, "R1 reset mid trap");
        cyc(1, 0, 0, 0, 0, 0, 0, NONE, "R1 idle after reset");

        cyc(1, 0, 0, 0, 0, 0, 0, NONE, "R1 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule